// File: doc/BRIEF.md
# Driver Projected-Event Queue

This block keeps the list of pending future events for a single signal driver in an event-driven logic model. Every entry pairs a value with an absolute time, and the list stays sorted from earliest to latest. When the earliest entry is due, it leaves the list and its value is placed on the driver output. A one-cycle strobe marks a real change of that output.

Each cycle the block can accept one new event. Its time is the current time input plus a delay. A mode input picks how it treats the events already queued. In transport mode, pulses of any width pass through. In inertial mode, a new event wipes out the pending events that would have formed a pulse shorter than its delay. An assignment that schedules several values is fed in as several inserts, one per cycle. Combining several drivers into one signal value is done elsewhere.

The time input is an absolute counter from the surrounding scheduler. It may advance by one per cycle or stay put for zero-time (delta) steps. Times are treated as unsigned and are assumed not to wrap.

Top module: `evq_driver`

## Requirements
- R1: After reset the driver output equals the reset value parameter (default 0), the queue is empty and not full, and both the change strobe and the overflow flag are low.
- R2: Entries leave the queue in ascending time order. When the head entry's time is not later than the time input at a rising clock edge, the head is removed at that edge and its value appears on the driver output right after it.
- R3: An event inserted with zero delay is never seen on the output after the edge that stores it. It appears after the following edge, even if the time input has not moved.
- R4: A transport insert first erases every queued entry whose time is strictly later than the new event's time. Entries at earlier or equal times stay, and the new event is placed after them.
- R5: An inertial insert keeps only those queued entries that are strictly earlier than the new event's time and carry the same value. All other entries, later ones included, are erased, so the new event becomes the last entry.
- R6: A sequence of transport inserts passes a pulse shorter than the delay to the output. The same sequence of inertial inserts suppresses it completely.
- R7: The change strobe is high for exactly the cycle after a removal whose value differs from the previous driver output. It is low after any other cycle.
- R8: The full flag is high exactly when DEPTH entries are held (default 8). The empty flag is high exactly when none are held.
- R9: An insert presented while the full flag is high is dropped and leaves the queue unchanged. It sets an overflow flag that stays high until reset.
- R10: When a removal and an insert happen in the same cycle, the removal comes first. The erase rules apply only to the entries that remain after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | TIME_W (16) | Current absolute simulation time |
| ev_valid | input | 1 | A new event is offered this cycle |
| ev_value | input | VAL_W (2) | Value carried by the new event |
| ev_delay | input | DLY_W (8) | Delay added to now_time to form the event time |
| ev_transport | input | 1 | 1 = transport rules, 0 = inertial rules |
| drv_value | output | VAL_W (2) | Current driver value |
| drv_change | output | 1 | Pulse: the driver value just changed |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| q_overflow | output | 1 | Sticky: an insert was dropped while full |

## Verification
The assertions assume that now_time never goes backward, and that now_time plus the largest delay stays within TIME_W bits. Under these conditions the queue stays sorted and every entry becomes due. The stimulus meets both conditions. It only holds or increments the time, starts it from small values, and keeps the whole run far below the wrap point. Directed sequences cover held time (zero-time steps), removal and insert in the same cycle, and filling the queue past its depth. Random phases vary mode, value and delay.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // How an insert treats the events already queued.
  typedef enum logic {
    MODE_INERTIAL  = 1'b0,
    MODE_TRANSPORT = 1'b1
  } evq_mode_e;

endpackage

// File: rtl/evq_keep.sv
// Decides which queued entries survive a new insert.
module evq_keep
  import evq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int VAL_W  = 2,
  parameter int TIME_W = 16
) (
  input  logic [DEPTH-1:0]             valid,
  input  logic [DEPTH-1:0][TIME_W-1:0] times,
  input  logic [DEPTH-1:0][VAL_W-1:0]  vals,
  input  logic                         ins,
  input  evq_mode_e                    mode,
  input  logic [TIME_W-1:0]            t_new,
  input  logic [VAL_W-1:0]             v_new,
  output logic [DEPTH-1:0]             keep
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic tr_ok;
    logic in_ok;
    // Transport: anything strictly after the new time goes.
    assign tr_ok = (times[i] <= t_new);
    // Inertial: only earlier entries that agree with the new value stay.
    assign in_ok = (times[i] < t_new) && (vals[i] == v_new);
    always_comb begin
      if (!valid[i])             keep[i] = 1'b0;
      else if (!ins)             keep[i] = 1'b1;
      else if (mode == MODE_TRANSPORT) keep[i] = tr_ok;
      else                       keep[i] = in_ok;
    end
  end

endmodule

// File: rtl/evq_pack.sv
// Squeezes surviving entries to the front and appends the new event.
module evq_pack #(
  parameter int DEPTH  = 8,
  parameter int VAL_W  = 2,
  parameter int TIME_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             keep,
  input  logic [DEPTH-1:0][TIME_W-1:0] times,
  input  logic [DEPTH-1:0][VAL_W-1:0]  vals,
  input  logic                         ins,
  input  logic [TIME_W-1:0]            t_new,
  input  logic [VAL_W-1:0]             v_new,
  output logic [DEPTH-1:0][TIME_W-1:0] o_times,
  output logic [DEPTH-1:0][VAL_W-1:0]  o_vals,
  output logic [CNT_W-1:0]             o_cnt
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] pos;

  always_comb begin
    o_times = '0;
    o_vals  = '0;
    pos     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        o_times[pos[IDX_W-1:0]] = times[i];
        o_vals[pos[IDX_W-1:0]]  = vals[i];
        pos = pos + ONE;
      end
    end
    o_cnt = pos;
    if (ins && (pos < FULL)) begin
      o_times[pos[IDX_W-1:0]] = t_new;
      o_vals[pos[IDX_W-1:0]]  = v_new;
      o_cnt = pos + ONE;
    end
  end

endmodule

// File: rtl/evq_driver.sv
// Projected-event queue of one driver: sorted (value, time) list.
module evq_driver
  import evq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int VAL_W  = 2,
  parameter int TIME_W = 16,
  parameter int DLY_W  = 8,
  parameter logic [VAL_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              ev_valid,
  input  logic [VAL_W-1:0]  ev_value,
  input  logic [DLY_W-1:0]  ev_delay,
  input  logic              ev_transport,
  output logic [VAL_W-1:0]  drv_value,
  output logic              drv_change,
  output logic              q_full,
  output logic              q_empty,
  output logic              q_overflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // State registers
  logic [DEPTH-1:0][TIME_W-1:0] q_time, q_time_d;
  logic [DEPTH-1:0][VAL_W-1:0]  q_val,  q_val_d;
  logic [CNT_W-1:0]             q_cnt,  q_cnt_d;
  logic [VAL_W-1:0]             drv_q,  drv_d;
  logic                         chg_q,  chg_d;
  logic                         ovf_q,  ovf_d;

  // Stage 1: removal of the due head (happens before any insert).
  logic                         retire;
  logic [DEPTH-1:0][TIME_W-1:0] s_time;
  logic [DEPTH-1:0][VAL_W-1:0]  s_val;
  logic [CNT_W-1:0]             s_cnt;
  logic [DEPTH-1:0]             s_valid;

  // Stage 2: insert with erase rules.
  logic                         accept;
  logic [TIME_W-1:0]            t_new;
  evq_mode_e                    mode;
  logic [DEPTH-1:0]             keep;

  assign q_full  = (q_cnt == FULL_CNT);
  assign q_empty = (q_cnt == '0);
  assign retire  = !q_empty && (q_time[0] <= now_time);
  assign accept  = ev_valid && !q_full;
  assign mode    = ev_transport ? MODE_TRANSPORT : MODE_INERTIAL;
  assign t_new   = now_time + {{(TIME_W-DLY_W){1'b0}}, ev_delay};

  always_comb begin
    if (retire) begin
      s_time = q_time >> TIME_W;
      s_val  = q_val  >> VAL_W;
      s_cnt  = q_cnt - CNT_W'(1);
    end else begin
      s_time = q_time;
      s_val  = q_val;
      s_cnt  = q_cnt;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    assign s_valid[i] = (CNT_W'(i) < s_cnt);
  end

  evq_keep #(
    .DEPTH (DEPTH),
    .VAL_W (VAL_W),
    .TIME_W(TIME_W)
  ) u_keep (
    .valid(s_valid),
    .times(s_time),
    .vals (s_val),
    .ins  (accept),
    .mode (mode),
    .t_new(t_new),
    .v_new(ev_value),
    .keep (keep)
  );

  evq_pack #(
    .DEPTH (DEPTH),
    .VAL_W (VAL_W),
    .TIME_W(TIME_W)
  ) u_pack (
    .keep   (keep),
    .times  (s_time),
    .vals   (s_val),
    .ins    (accept),
    .t_new  (t_new),
    .v_new  (ev_value),
    .o_times(q_time_d),
    .o_vals (q_val_d),
    .o_cnt  (q_cnt_d)
  );

  // Driver output and status next state.
  always_comb begin
    drv_d = drv_q;
    chg_d = 1'b0;
    if (retire) begin
      drv_d = q_val[0];
      chg_d = (q_val[0] != drv_q);
    end
    ovf_d = ovf_q | (ev_valid & q_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_time <= '0;
      q_val  <= '0;
      q_cnt  <= '0;
      drv_q  <= RST_VAL;
      chg_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      q_time <= q_time_d;
      q_val  <= q_val_d;
      q_cnt  <= q_cnt_d;
      drv_q  <= drv_d;
      chg_q  <= chg_d;
      ovf_q  <= ovf_d;
    end
  end

  assign drv_value  = drv_q;
  assign drv_change = chg_q;
  assign q_overflow = ovf_q;

  // ---------------- assertions ----------------
  a_r8_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= FULL_CNT);

  a_r7_strobe_real_change: assert property (@(posedge clk) disable iff (!rst_n)
    drv_change |-> (drv_value != $past(drv_value)));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |=> q_overflow);

  a_r3_no_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && q_empty && ev_delay == '0) |=> $stable(drv_value));

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order
    a_r2_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt > CNT_W'(i + 1)) |-> (q_time[i] <= q_time[i+1]));
  end

endmodule

// File: tb/evq_driver_test.sv
`timescale 1ns/1ps
module evq_driver_test;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] now_time;
  logic        ev_valid;
  logic [1:0]  ev_value;
  logic [7:0]  ev_delay;
  logic        ev_transport;
  logic [1:0]  drv_value;
  logic        drv_change;
  logic        q_full;
  logic        q_empty;
  logic        q_overflow;

  always #2.5 clk = ~clk;

  evq_driver uut (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .ev_valid(ev_valid), .ev_value(ev_value), .ev_delay(ev_delay),
    .ev_transport(ev_transport), .drv_value(drv_value),
    .drv_change(drv_change), .q_full(q_full), .q_empty(q_empty),
    .q_overflow(q_overflow)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  int m_t[0:DEPTH-1];
  int m_v[0:DEPTH-1];
  int m_n;
  int m_drv;
  bit m_chg;
  bit m_ovf;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_n = 0; m_drv = 0; m_chg = 0; m_ovf = 0;
  endtask

  // One clock step, applying the requirement rules to the model.
  task automatic model_step(input bit v, input int val, input int d, input bit tr, input int now);
    bit was_full;
    int tn, k;
    int nt[0:DEPTH-1];
    int nv[0:DEPTH-1];
    was_full = (m_n == DEPTH);
    m_chg = 0;
    if (m_n > 0 && m_t[0] <= now) begin          // R10: removal first
      m_chg = (m_v[0] != m_drv);
      m_drv = m_v[0];
      for (int j = 0; j < DEPTH - 1; j++) begin
        m_t[j] = m_t[j+1]; m_v[j] = m_v[j+1];
      end
      m_n--;
    end
    if (v) begin
      if (was_full) m_ovf = 1;
      else begin
        tn = now + d;
        k = 0;
        for (int j = 0; j < m_n; j++) begin
          if (tr ? (m_t[j] <= tn) : (m_t[j] < tn && m_v[j] == val)) begin
            nt[k] = m_t[j]; nv[k] = m_v[j]; k++;
          end
        end
        nt[k] = tn; nv[k] = val;
        m_n = k + 1;
        for (int j = 0; j < m_n; j++) begin
          m_t[j] = nt[j]; m_v[j] = nv[j];
        end
      end
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic cyc(input bit v, input int val, input int d, input bit tr, input bit adv);
    ev_valid = v; ev_value = val[1:0]; ev_delay = d[7:0]; ev_transport = tr;
    @(posedge clk);
    model_step(v, val, d, tr, int'(now_time));
    #1;
    chk("R2 drv_value", int'(drv_value), m_drv);
    chk("R7 drv_change", int'(drv_change), int'(m_chg));
    chk("R8 q_full", int'(q_full), int'(m_n == DEPTH));
    chk("R8 q_empty", int'(q_empty), int'(m_n == 0));
    chk("R9 q_overflow", int'(q_overflow), int'(m_ovf));
    @(negedge clk);
    ev_valid = 1'b0;
    if (adv) now_time = now_time + 16'd1;
  endtask

  task automatic do_reset(input int start);
    rst_n = 1'b0; ev_valid = 1'b0; ev_value = '0; ev_delay = '0;
    ev_transport = 1'b0; now_time = start[15:0];
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ones;
    int changes;
    void'($urandom(32'h00c0ffee));

    // R1: reset state
    do_reset(10);
    chk("R1 drv_value", int'(drv_value), 0);
    chk("R1 q_empty", int'(q_empty), 1);
    chk("R1 q_full", int'(q_full), 0);
    chk("R1 drv_change", int'(drv_change), 0);
    chk("R1 q_overflow", int'(q_overflow), 0);

    // R3: zero delay with time held
    cyc(1, 2, 0, 1, 0);
    chk("R3 not same cycle", int'(drv_value), 0);
    cyc(0, 0, 0, 0, 0);
    chk("R3 next cycle", int'(drv_value), 2);

    // R10: removal and inertial insert together
    do_reset(20);
    cyc(1, 1, 1, 1, 1);      // event at 21
    cyc(1, 3, 2, 0, 1);      // at 21: head due, then inertial event at 23
    chk("R10 head kept", int'(drv_value), 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10 later value", int'(drv_value), 3);

    // R6: transport passes a short pulse
    do_reset(100);
    ones = 0;
    cyc(1, 1, 3, 1, 1);
    cyc(1, 0, 3, 1, 1);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (drv_value == 2'd1) ones++;
    end
    chk("R6 transport pulse width", ones, 1);

    // R6: inertial suppresses the same pulse
    do_reset(100);
    ones = 0;
    cyc(1, 1, 5, 0, 1);
    cyc(1, 0, 5, 0, 1);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (drv_value == 2'd1) ones++;
    end
    chk("R6 inertial pulse removed", ones, 0);

    // R4: transport erases a later entry
    do_reset(30);
    ones = 0;
    cyc(1, 1, 6, 1, 1);      // 36
    cyc(1, 2, 2, 1, 1);      // 33, erases 36
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (drv_value == 2'd1) ones++;
    end
    chk("R4 later entry gone", ones, 0);
    chk("R4 final value", int'(drv_value), 2);
    chk("R4 drained", int'(q_empty), 1);

    // R5: inertial keeps an earlier same-value entry, drops the rest
    do_reset(40);
    ones = 0; changes = 0;
    cyc(1, 3, 4, 0, 1);      // (3,44)
    cyc(1, 1, 5, 1, 1);      // (1,46) transport
    cyc(1, 3, 6, 0, 1);      // (3,48) inertial: keep 44, drop 46
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, 1);
      if (drv_value == 2'd1) ones++;
      if (drv_change) changes++;
    end
    chk("R5 differing entry erased", ones, 0);
    chk("R5 single change", changes, 1);
    chk("R5 final value", int'(drv_value), 3);

    // R8 / R9: fill, overflow, drain
    do_reset(50);
    for (int i = 0; i < DEPTH; i++) cyc(1, i % 4, 10 + i, 1, 0);
    chk("R8 full after depth inserts", int'(q_full), 1);
    cyc(1, 0, 20, 1, 0);
    chk("R9 overflow set", int'(q_overflow), 1);
    for (int i = 0; i < 25; i++) cyc(0, 0, 0, 0, 1);
    chk("R9 dropped insert absent", int'(drv_value), (DEPTH - 1) % 4);
    chk("R9 overflow sticky", int'(q_overflow), 1);

    // Random phase
    do_reset(200);
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
          $urandom_range(0, 1), ($urandom_range(0, 7) != 0));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule